// File: doc/BRIEF.md
# Soft-Ramped Two-Channel Digital Attenuator

This block is the volume stage of a stereo 24-bit audio datapath. Once per sample frame it multiplies each channel's signed sample by a gain of `level/255`. The gain is linear in 256 steps: level 255 is unity, level 1 is about -48 dB and level 0 is silence. The result can be negated per channel, and it is clamped to the signed 24-bit range.

The gain never jumps. Each channel keeps an applied level that moves one step toward a goal each time a shared step timer expires. The timer period is 4, 8 or 16 frames, chosen by the sampling-speed code. The goal is the channel's target input, or zero while soft mute is held. Releasing mute, or changing a target, turns the ramp around from wherever it stands. A restart strobe clears the timer and loads each applied level directly with its goal.

Top module: `vol_ramp_stage`

## Requirements
- R1: On each frame, an output equals the sample times the applied level, divided by 255 and truncated toward zero (for example, -1000 at level 100 gives -392, and 254 at level 1 gives 0).
- R2: During and after reset both outputs read 0, both applied levels are 255 and the step timer is at zero. The first frame therefore passes the sample through unchanged.
- R3: The applied level changes by one step only on the frame that ends a step period. The period is 4 frames for speed code 0, 8 for code 1 and 16 for codes 2 and 3. A full sweep from 255 to 0 therefore reaches 0 after 1020, 2040 or 4080 frames.
- R4: While mute is 1, each applied level steps down toward 0 from its present value and never rises.
- R5: When mute returns to 0, each level steps toward its target from the value it had reached, at the same rate, including when the fall was stopped partway.
- R6: A target change during a ramp redirects the ramp. Outside a restart, an applied level moves by at most one per step.
- R7: The left and right channels have separate targets and levels, and neither affects the other's output.
- R8: When a channel's invert input is 1, its scaled result is negated. A negated -2^23 at unity saturates to 2^23-1 (0x7FFFFF), and an inverted output never reads 0x800000.
- R9: A restart pulse clears the step timer and sets each applied level to its goal: the target, or 0 if mute is 1.
- R10: The outputs are registered. They update on the clock edge that samples `frame_en` high and hold their value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_en | input | 1 | One-cycle strobe, once per sample frame |
| ramp_restart | input | 1 | Clears the step timer and loads each level with its goal |
| speed | input | 2 | Speed code: 0 normal, 1 double, 2 or 3 quad |
| mute | input | 1 | Soft mute: ramps both levels toward 0 |
| tgt_l | input | 8 | Left target level |
| tgt_r | input | 8 | Right target level |
| inv_l | input | 1 | Left polarity inversion |
| inv_r | input | 1 | Right polarity inversion |
| smp_l | input | 24 | Left signed input sample |
| smp_r | input | 24 | Right signed input sample |
| out_l | output | 24 | Left scaled signed sample |
| out_r | output | 24 | Right scaled signed sample |

## Verification
The bench measures, for each speed code, the exact number of frames a full sweep needs. A timer off by one shows up as a sweep one period too short or too long. A wrong speed decode gives twice or half the expected length. It also releases mute partway down and changes a target mid-ramp. A design that finished the fall before reversing, or jumped straight to the new goal, would disagree with the frame-by-frame reference. It sweeps every level with both full-scale samples, a negative sample that needs rounding and a small sample. This catches rounding toward minus infinity, a divide by 256 instead of 255, and a negated most-negative value that wraps instead of saturating.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_QUAD_B = 2'd3
  } spd_e;
endpackage

// File: rtl/vr_step_timer.sv
module vr_step_timer #(
  parameter int BASE_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_en,
  input  logic       restart,
  input  logic [1:0] speed,
  output logic       tick
);
  import vr_pkg::*;

  localparam int CW = BASE_LOG2 + 2;
  localparam logic [CW-1:0] LIM_N = CW'((1 << BASE_LOG2) - 1);
  localparam logic [CW-1:0] LIM_D = CW'((2 << BASE_LOG2) - 1);
  localparam logic [CW-1:0] LIM_Q = CW'((4 << BASE_LOG2) - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  spd_e          spd;

  assign spd = spd_e'(speed);

  always_comb begin
    unique case (spd)
      SPD_NORMAL: lim = LIM_N;
      SPD_DOUBLE: lim = LIM_D;
      default:    lim = LIM_Q;
    endcase
  end

  assign tick = frame_en && !restart && (cnt_q >= lim);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)       cnt_d = '0;
    else if (tick)     cnt_d = '0;
    else if (frame_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vr_level_ramp.sv
module vr_level_ramp #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          mute,
  input  logic [LW-1:0] target,
  output logic [LW-1:0] lvl
);
  logic [LW-1:0] lvl_q, lvl_d, goal;

  assign goal = mute ? '0 : target;

  always_comb begin
    lvl_d = lvl_q;
    if (restart) begin
      lvl_d = goal;
    end else if (tick) begin
      if (lvl_q < goal)      lvl_d = lvl_q + LW'(1);
      else if (lvl_q > goal) lvl_d = lvl_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl_d;
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/vr_gain_scale.sv
module vr_gain_scale #(
  parameter int DW = 24,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_en,
  input  logic [DW-1:0] smp,
  input  logic [LW-1:0] lvl,
  input  logic          inv,
  output logic [DW-1:0] out
);
  localparam int PW = DW + LW + 1;
  localparam logic signed [PW-1:0] DIVR   = PW'((1 << LW) - 1);
  localparam logic signed [PW-1:0] SAT_HI = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] SAT_LO = -(PW'(1 << (DW - 1)));

  logic signed [PW-1:0] prod, quo, adj;
  logic        [DW-1:0] out_d, out_q;

  always_comb begin
    prod = $signed(smp) * $signed({1'b0, lvl});
    quo  = prod / DIVR;
    adj  = inv ? -quo : quo;
    if (adj > SAT_HI)      out_d = SAT_HI[DW-1:0];
    else if (adj < SAT_LO) out_d = SAT_LO[DW-1:0];
    else                   out_d = adj[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= '0;
    else if (frame_en) out_q <= out_d;
  end

  assign out = out_q;
endmodule

// File: rtl/vol_ramp_stage.sv
module vol_ramp_stage #(
  parameter int DW        = 24,
  parameter int LW        = 8,
  parameter int BASE_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_en,
  input  logic          ramp_restart,
  input  logic [1:0]    speed,
  input  logic          mute,
  input  logic [LW-1:0] tgt_l,
  input  logic [LW-1:0] tgt_r,
  input  logic          inv_l,
  input  logic          inv_r,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r
);
  localparam int NCH = 2;

  logic          step_tick;
  logic [LW-1:0] tgt_a [NCH];
  logic          inv_a [NCH];
  logic [DW-1:0] smp_a [NCH];
  logic [DW-1:0] out_a [NCH];
  logic [LW-1:0] lvl_q [NCH];

  assign tgt_a[0] = tgt_l;
  assign tgt_a[1] = tgt_r;
  assign inv_a[0] = inv_l;
  assign inv_a[1] = inv_r;
  assign smp_a[0] = smp_l;
  assign smp_a[1] = smp_r;
  assign out_l    = out_a[0];
  assign out_r    = out_a[1];

  vr_step_timer #(.BASE_LOG2(BASE_LOG2)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_en (frame_en),
    .restart  (ramp_restart),
    .speed    (speed),
    .tick     (step_tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    vr_level_ramp #(.LW(LW)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (step_tick),
      .restart (ramp_restart),
      .mute    (mute),
      .target  (tgt_a[ch]),
      .lvl     (lvl_q[ch])
    );

    vr_gain_scale #(.DW(DW), .LW(LW)) u_scale (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_en (frame_en),
      .smp      (smp_a[ch]),
      .lvl      (lvl_q[ch]),
      .inv      (inv_a[ch]),
      .out      (out_a[ch])
    );
  end
endmodule

// File: rtl/vr_chk.sv
module vr_chk #(
  parameter int DW = 24,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_en,
  input logic          ramp_restart,
  input logic          mute,
  input logic          inv_l,
  input logic          inv_r,
  input logic          tick,
  input logic [LW-1:0] lvl_l,
  input logic [LW-1:0] lvl_r,
  input logic [DW-1:0] out_l,
  input logic [DW-1:0] out_r
);
  localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};

  // R3
  tick_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> frame_en);

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ramp_restart) |=> ($stable(lvl_l) && $stable(lvl_r)));

  // R4
  mute_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && !ramp_restart) |=> ((lvl_l <= $past(lvl_l)) && (lvl_r <= $past(lvl_r))));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_restart |=>
      ((({1'b0, lvl_l} == {1'b0, $past(lvl_l)}) ||
        ({1'b0, lvl_l} == {1'b0, $past(lvl_l)} + 1'b1) ||
        ({1'b0, lvl_l} + 1'b1 == {1'b0, $past(lvl_l)})) &&
       (({1'b0, lvl_r} == {1'b0, $past(lvl_r)}) ||
        ({1'b0, lvl_r} == {1'b0, $past(lvl_r)} + 1'b1) ||
        ({1'b0, lvl_r} + 1'b1 == {1'b0, $past(lvl_r)}))));

  // R8
  inv_no_negfs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_en) && $past(inv_l)) |-> (out_l != NEG_FS));

  // R8
  inv_no_negfs_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_en) && $past(inv_r)) |-> (out_r != NEG_FS));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |=> ($stable(out_l) && $stable(out_r)));
endmodule

bind vol_ramp_stage vr_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_en     (frame_en),
  .ramp_restart (ramp_restart),
  .mute         (mute),
  .inv_l        (inv_l),
  .inv_r        (inv_r),
  .tick         (step_tick),
  .lvl_l        (lvl_q[0]),
  .lvl_r        (lvl_q[1]),
  .out_l        (out_l),
  .out_r        (out_r)
);

// File: tb/vol_ramp_stage_bench.sv
`timescale 1ns/1ps
module vol_ramp_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_en, ramp_restart, mute, inv_l, inv_r;
  logic [1:0]  speed;
  logic [7:0]  tgt_l, tgt_r;
  logic [23:0] smp_l, smp_r, out_l, out_r;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int m_lvl [2];
  int m_cnt;

  always #2.5 clk = ~clk;

  vol_ramp_stage u_vol_ramp_stage (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .ramp_restart(ramp_restart),
    .speed(speed), .mute(mute), .tgt_l(tgt_l), .tgt_r(tgt_r),
    .inv_l(inv_l), .inv_r(inv_r), .smp_l(smp_l), .smp_r(smp_r),
    .out_l(out_l), .out_r(out_r)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      finish_run();
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_scale(int s, int l, bit inv);
    longint q;
    q = (longint'(s) * longint'(l)) / 255;
    if (inv) q = -q;
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return int'(q);
  endfunction

  function automatic int goal_of(int ch);
    if (mute) return 0;
    return (ch == 0) ? int'(tgt_l) : int'(tgt_r);
  endfunction

  task automatic do_frame(int sl, int sr, string tag);
    int el, er, per;
    @(negedge clk);
    smp_l = sl[23:0];
    smp_r = sr[23:0];
    frame_en = 1'b1;
    el = exp_scale(sl, m_lvl[0], inv_l);
    er = exp_scale(sr, m_lvl[1], inv_r);
    per = 4 << ((speed >= 2'd2) ? 2 : int'(speed));
    @(negedge clk);
    frame_en = 1'b0;
    chk(tag, $signed(out_l), el);
    chk(tag, $signed(out_r), er);
    if (m_cnt >= per - 1) begin
      m_cnt = 0;
      for (int ch = 0; ch < 2; ch++) begin
        if (m_lvl[ch] < goal_of(ch)) m_lvl[ch]++;
        else if (m_lvl[ch] > goal_of(ch)) m_lvl[ch]--;
      end
    end else begin
      m_cnt++;
    end
  endtask

  task automatic restart();
    @(negedge clk);
    ramp_restart = 1'b1;
    @(negedge clk);
    ramp_restart = 1'b0;
    m_cnt = 0;
    m_lvl[0] = goal_of(0);
    m_lvl[1] = goal_of(1);
  endtask

  task automatic sweep(logic [1:0] spd, int exp_frames);
    int n;
    speed = spd;
    tgt_l = 8'd255;
    tgt_r = 8'd255;
    restart();
    tgt_l = 8'd0;
    n = 0;
    do begin
      do_frame(25500, 25500, "R3");
      n++;
    end while ($signed(out_l) != 0 && n < 6000);
    // R3: first zero output comes one frame after the last step
    chk("R3", n, exp_frames);
    // R7: right channel untouched by left sweep
    chk("R7", $signed(out_r), 25500);
  endtask

  initial begin
    int hold;
    rst_n = 1'b0; frame_en = 1'b0; ramp_restart = 1'b0; mute = 1'b0;
    inv_l = 1'b0; inv_r = 1'b0; speed = 2'd0;
    tgt_l = 8'd255; tgt_r = 8'd255; smp_l = '0; smp_r = '0;
    m_lvl[0] = 255; m_lvl[1] = 255; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R2", $signed(out_l), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", $signed(out_r), 0);
    do_frame(1234567, -7654321, "R2");

    sweep(2'd0, 1021);
    sweep(2'd1, 2041);
    sweep(2'd2, 4081);

    // R3: code 3 behaves as quad, 150 frames against the model
    speed = 2'd3; tgt_l = 8'd255; tgt_r = 8'd255; restart();
    tgt_l = 8'd10; tgt_r = 8'd200;
    for (int i = 0; i < 150; i++) do_frame(-25500, 25500, "R3");

    // R4 / R5: mute partway, release, full mute, release
    speed = 2'd0; tgt_l = 8'd200; tgt_r = 8'd100; restart();
    mute = 1'b1;
    for (int i = 0; i < 300; i++) do_frame(25500, -25500, "R4");
    chk("R4", $signed(out_l), 12600);
    mute = 1'b0;
    for (int i = 0; i < 400; i++) do_frame(25500, -25500, "R5");
    mute = 1'b1;
    for (int i = 0; i < 900; i++) do_frame(25500, 25500, "R4");
    chk("R4", $signed(out_l), 0);
    mute = 1'b0;
    for (int i = 0; i < 200; i++) do_frame(25500, 25500, "R5");

    // R6: redirect mid-ramp
    speed = 2'd1; tgt_l = 8'd255; tgt_r = 8'd0; restart();
    tgt_l = 8'd0; tgt_r = 8'd255;
    for (int i = 0; i < 200; i++) do_frame(25500, 25500, "R6");
    tgt_l = 8'd250; tgt_r = 8'd3;
    for (int i = 0; i < 300; i++) do_frame(25500, 25500, "R6");

    // R9: restart while muted loads zero; restart unmuted loads target
    mute = 1'b1; restart();
    do_frame(25500, 25500, "R9");
    chk("R9", $signed(out_l), 0);
    mute = 1'b0; tgt_l = 8'd77; restart();
    do_frame(25500, 25500, "R9");
    chk("R9", $signed(out_l), 7700);

    // R1 / R8: every level, several samples, both polarities
    speed = 2'd0;
    for (int lv = 0; lv < 256; lv++) begin
      tgt_l = lv[7:0]; tgt_r = lv[7:0]; restart();
      inv_l = 1'b0; inv_r = 1'b1;
      do_frame(8388607, -8388608, "R8");
      do_frame(-1000, 254, "R1");
      inv_l = 1'b1; inv_r = 1'b0;
      do_frame(-8388608, -1000, "R8");
    end
    inv_l = 1'b0; inv_r = 1'b0;
    tgt_l = 8'd100; tgt_r = 8'd1; restart();
    do_frame(-1000, -254, "R1");
    chk("R1", $signed(out_l), -392);
    chk("R1", $signed(out_r), 0);
    tgt_l = 8'd255; tgt_r = 8'd255; inv_l = 1'b1; restart();
    do_frame(-8388608, -8388608, "R8");
    chk("R8", $signed(out_l), 8388607);
    chk("R8", $signed(out_r), -8388608);
    inv_l = 1'b0;

    // R10: output holds between frames
    hold = $signed(out_l);
    smp_l = 24'd5000; smp_r = 24'd5000;
    repeat (4) @(negedge clk);
    chk("R10", $signed(out_l), hold);
    do_frame(5000, 5000, "R10");
    chk("R10", $signed(out_l), 5000);

    finish_run();
  end
endmodule